// File: doc/BRIEF.md
# Per-Core Fast Accelerator Interrupt Dispatcher

This unit sits beside a processor core and takes interrupt packets sent by loosely coupled accelerators, such as an address-translation miss or a notice that a task has finished. Each hardware thread may register one entry in a small table. The entry holds the handler address, a handler argument word and the single packet source that the thread accepts. A packet that names a registered thread, carries the registered source and arrives while that thread is running is placed in a short pending queue. The unit then hands these packets one at a time to the core as a fast dispatch that carries the handler address and argument from the table.

Every other packet goes out on a separate port to the ordinary operating-system interrupt path, and no packet is ever lost. This covers packets for threads that are not running, packets with an unregistered thread or a wrong source, and packets that find the queue full. Queued packets can also leave by that port later. This happens when their table entry is cleared or changed, or when the core switches to another thread.

Top module: `lwint_ctrl`

## Requirements
- R1: A table write with `tbl_set`=1 registers handler address, argument and accepted source for `tbl_thread`. A write with `tbl_set`=0 removes that thread's registration.
- R2: A packet is accepted for fast dispatch when three things hold: its thread is registered, its source equals the registered source, and its thread equals `cur_thread` on arrival. With no dispatch outstanding, `disp_valid` then rises in the second cycle after the packet is sampled. It carries the table's address and argument with the packet's thread and tag.
- R3: `disp_valid` is high for exactly one cycle. No further dispatch is issued until `disp_ack` has been sampled high. The next dispatch may appear the cycle after the acknowledge.
- R4: Among queued packets eligible for dispatch, one with `pkt_miss`=1 (translation miss) is dispatched before any with `pkt_miss`=0 (task done).
- R5: Eligible packets of equal priority are dispatched in arrival order.
- R6: A registered, source-matching packet whose thread is not `cur_thread` on arrival appears on the OS port (`os_valid` with its thread, source and tag) in the first cycle after it is sampled.
- R7: A packet for an unregistered thread, or one whose source differs from the registered source, goes to the OS port in the first cycle after it is sampled.
- R8: When the queue already holds QDEPTH packets, a new packet goes to the OS port instead. The queued packets are all still dispatched later.
- R9: Clearing a thread's entry sends that thread's queued packets to the OS port, oldest first, one per cycle. This starts the cycle after the write. None of them is dispatched afterwards.
- R10: When `cur_thread` changes, queued packets of the thread no longer running drain to the OS port in arrival order.
- R11: After reset the table is empty, the queue is empty, and `disp_valid` and `os_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_thread | input | TW | Thread whose entry is written |
| tbl_set | input | 1 | 1 registers, 0 clears |
| tbl_src | input | SRC_W | Accepted packet source |
| tbl_addr | input | ADDR_W | Handler address |
| tbl_arg | input | ARG_W | Handler argument |
| cur_thread | input | TW | Thread currently running on the core |
| pkt_valid | input | 1 | Packet present |
| pkt_thread | input | TW | Owning thread of the packet |
| pkt_src | input | SRC_W | Packet source |
| pkt_miss | input | 1 | 1 translation miss, 0 task done |
| pkt_tag | input | TAG_W | Packet identifier |
| disp_valid | output | 1 | One-cycle fast dispatch strobe |
| disp_thread | output | TW | Thread of the dispatched packet |
| disp_addr | output | ADDR_W | Handler address |
| disp_arg | output | ARG_W | Handler argument |
| disp_tag | output | TAG_W | Tag of the dispatched packet |
| disp_ack | input | 1 | Core accepted the dispatch |
| os_valid | output | 1 | Packet handed to the OS path |
| os_thread | output | TW | Its thread |
| os_src | output | SRC_W | Its source |
| os_tag | output | TAG_W | Its tag |

## Verification
A corrupted queue order shows up at once as the wrong tag on the next dispatch after an acknowledge. A lost busy flag shows up as a second `disp_valid` before the acknowledge, visible within one cycle. A stale table or eligibility decision moves a packet to the wrong port: the dispatch port two cycles after arrival, or the OS port one cycle after. Since every packet carries a unique tag, a dropped or duplicated packet is exposed when the bench collects tags from both ports.

// File: rtl/lwint_ctrl.sv
module lwint_ctrl #(
  parameter int THREADS = 4,
  parameter int SRC_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int ARG_W   = 32,
  parameter int TAG_W   = 8,
  parameter int QDEPTH  = 4,
  localparam int TW = $clog2(THREADS),
  localparam int QW = $clog2(QDEPTH),
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [TW-1:0]     tbl_thread,
  input  logic              tbl_set,
  input  logic [SRC_W-1:0]  tbl_src,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ARG_W-1:0]  tbl_arg,
  input  logic [TW-1:0]     cur_thread,
  input  logic              pkt_valid,
  input  logic [TW-1:0]     pkt_thread,
  input  logic [SRC_W-1:0]  pkt_src,
  input  logic              pkt_miss,
  input  logic [TAG_W-1:0]  pkt_tag,
  output logic              disp_valid,
  output logic [TW-1:0]     disp_thread,
  output logic [ADDR_W-1:0] disp_addr,
  output logic [ARG_W-1:0]  disp_arg,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              disp_ack,
  output logic              os_valid,
  output logic [TW-1:0]     os_thread,
  output logic [SRC_W-1:0]  os_src,
  output logic [TAG_W-1:0]  os_tag
);

  logic              t_vld  [THREADS];
  logic [SRC_W-1:0]  t_src  [THREADS];
  logic [ADDR_W-1:0] t_addr [THREADS];
  logic [ARG_W-1:0]  t_arg  [THREADS];

  logic [TW-1:0]    q_thr  [QDEPTH];
  logic [SRC_W-1:0] q_src  [QDEPTH];
  logic             q_miss [QDEPTH];
  logic [TAG_W-1:0] q_tag  [QDEPTH];
  logic [CW-1:0]    q_cnt;
  logic             busy;

  logic [QDEPTH-1:0] elig, stale;
  logic [QW-1:0]     dsel, ssel, ridx, wslot;
  logic              a_q, a_os, do_disp, do_drain, rm;

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      elig[i]  = (CW'(i) < q_cnt) && t_vld[q_thr[i]] && (t_src[q_thr[i]] == q_src[i])
                 && (q_thr[i] == cur_thread);
      stale[i] = (CW'(i) < q_cnt) && !elig[i];
    end
    dsel = '0;
    ssel = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (elig[i] && !q_miss[i]) dsel = QW'(i);
      if (stale[i]) ssel = QW'(i);
    end
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (elig[i] && q_miss[i]) dsel = QW'(i);
  end

  assign a_q      = pkt_valid && t_vld[pkt_thread] && (t_src[pkt_thread] == pkt_src)
                    && (pkt_thread == cur_thread) && (q_cnt != CW'(QDEPTH));
  assign a_os     = pkt_valid && !a_q;
  assign do_disp  = (|elig) && !busy;
  assign do_drain = !do_disp && (|stale) && !a_os;
  assign rm       = do_disp || do_drain;
  assign ridx     = do_disp ? dsel : ssel;
  assign wslot    = QW'(q_cnt - CW'(rm));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) begin
        t_vld[t]  <= 1'b0;
        t_src[t]  <= '0;
        t_addr[t] <= '0;
        t_arg[t]  <= '0;
      end
    end else if (tbl_we) begin
      t_vld[tbl_thread] <= tbl_set;
      if (tbl_set) begin
        t_src[tbl_thread]  <= tbl_src;
        t_addr[tbl_thread] <= tbl_addr;
        t_arg[tbl_thread]  <= tbl_arg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_thr[i]  <= '0;
        q_src[i]  <= '0;
        q_miss[i] <= 1'b0;
        q_tag[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < QDEPTH - 1; i++) begin
        if (rm && QW'(i) >= ridx) begin
          q_thr[i]  <= q_thr[i+1];
          q_src[i]  <= q_src[i+1];
          q_miss[i] <= q_miss[i+1];
          q_tag[i]  <= q_tag[i+1];
        end
      end
      if (a_q) begin
        q_thr[wslot]  <= pkt_thread;
        q_src[wslot]  <= pkt_src;
        q_miss[wslot] <= pkt_miss;
        q_tag[wslot]  <= pkt_tag;
      end
      q_cnt <= q_cnt - CW'(rm) + CW'(a_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_valid  <= 1'b0;
      busy        <= 1'b0;
      disp_thread <= '0;
      disp_addr   <= '0;
      disp_arg    <= '0;
      disp_tag    <= '0;
    end else begin
      disp_valid <= do_disp;
      if (do_disp) begin
        busy        <= 1'b1;
        disp_thread <= q_thr[dsel];
        disp_addr   <= t_addr[q_thr[dsel]];
        disp_arg    <= t_arg[q_thr[dsel]];
        disp_tag    <= q_tag[dsel];
      end else if (busy && disp_ack) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_valid  <= 1'b0;
      os_thread <= '0;
      os_src    <= '0;
      os_tag    <= '0;
    end else begin
      os_valid <= a_os || do_drain;
      if (a_os) begin
        os_thread <= pkt_thread;
        os_src    <= pkt_src;
        os_tag    <= pkt_tag;
      end else if (do_drain) begin
        os_thread <= q_thr[ssel];
        os_src    <= q_src[ssel];
        os_tag    <= q_tag[ssel];
      end
    end
  end

  // R3
  disp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);

  // R3
  ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !disp_ack |=> !disp_valid);

  // R2
  owner_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_thread == $past(cur_thread));

  // R8
  full_to_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && q_cnt == CW'(QDEPTH) |=> os_valid && os_tag == $past(pkt_tag));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QDEPTH));

endmodule

// File: tb/test_lwint_ctrl.sv
module test_lwint_ctrl;
  localparam int TW = 2, SW = 3, AW = 32, GW = 32, TGW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 0, tbl_set = 0;
  logic [TW-1:0] tbl_thread = '0, cur_thread = '0, pkt_thread = '0;
  logic [SW-1:0] tbl_src = '0, pkt_src = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [GW-1:0] tbl_arg = '0;
  logic pkt_valid = 0, pkt_miss = 0, disp_ack = 0;
  logic [TGW-1:0] pkt_tag = '0;
  logic disp_valid, os_valid;
  logic [TW-1:0] disp_thread, os_thread;
  logic [AW-1:0] disp_addr;
  logic [GW-1:0] disp_arg;
  logic [TGW-1:0] disp_tag, os_tag;
  logic [SW-1:0] os_src;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lwint_ctrl i_lwint_ctrl (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_thread(tbl_thread), .tbl_set(tbl_set), .tbl_src(tbl_src),
    .tbl_addr(tbl_addr), .tbl_arg(tbl_arg), .cur_thread(cur_thread),
    .pkt_valid(pkt_valid), .pkt_thread(pkt_thread), .pkt_src(pkt_src),
    .pkt_miss(pkt_miss), .pkt_tag(pkt_tag),
    .disp_valid(disp_valid), .disp_thread(disp_thread), .disp_addr(disp_addr),
    .disp_arg(disp_arg), .disp_tag(disp_tag), .disp_ack(disp_ack),
    .os_valid(os_valid), .os_thread(os_thread), .os_src(os_src), .os_tag(os_tag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic tbl(input logic [TW-1:0] th, input logic set, input logic [SW-1:0] s,
                     input logic [AW-1:0] a, input logic [GW-1:0] g);
    @(negedge clk);
    tbl_we = 1; tbl_thread = th; tbl_set = set; tbl_src = s; tbl_addr = a; tbl_arg = g;
    tick();
    tbl_we = 0;
  endtask

  // returns with os_* sampled for the cycle after the packet edge
  task automatic send(input logic [TW-1:0] th, input logic [SW-1:0] s, input logic m,
                      input logic [TGW-1:0] tg);
    @(negedge clk);
    pkt_valid = 1; pkt_thread = th; pkt_src = s; pkt_miss = m; pkt_tag = tg;
    tick();
    pkt_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk);
    disp_ack = 1;
    tick();
    disp_ack = 0;
  endtask

  task automatic next_disp(input string req, input logic [TGW-1:0] exp_tag);
    logic seen = 0;
    for (int c = 0; c < 8 && !seen; c++) begin
      tick();
      if (disp_valid) begin
        seen = 1;
        check(req, disp_tag, exp_tag);
      end
    end
    if (!seen) check({req, " dispatch missing"}, 0, 1);
  endtask

  task automatic quiet_disp(input string req, input int cycles);
    int hits = 0;
    for (int c = 0; c < cycles; c++) begin
      tick();
      if (disp_valid) hits++;
    end
    check(req, hits, 0);
  endtask

  task automatic t_reset();
    check("R11 disp_valid", disp_valid, 0);
    check("R11 os_valid", os_valid, 0);
  endtask

  task automatic t_basic();
    tbl(0, 1, 3, 32'hA000_0100, 32'h0000_CAFE);
    send(0, 3, 0, 8'h11);
    check("R2 no os", os_valid, 0);
    tick();
    check("R2 disp_valid", disp_valid, 1);
    check("R1 R2 addr", disp_addr, 32'hA000_0100);
    check("R1 R2 arg", disp_arg, 32'h0000_CAFE);
    check("R2 thread", disp_thread, 0);
    check("R2 tag", disp_tag, 8'h11);
    tick();
    check("R3 one cycle", disp_valid, 0);
    ack();
  endtask

  task automatic t_handshake();
    send(0, 3, 0, 8'h21);
    next_disp("R3 first", 8'h21);
    send(0, 3, 0, 8'h22);
    quiet_disp("R3 held until ack", 5);
    ack();
    tick();
    check("R3 after ack", disp_valid, 1);
    check("R3 after ack tag", disp_tag, 8'h22);
    ack();
  endtask

  task automatic t_prio();
    send(0, 3, 0, 8'h30);
    next_disp("R4 head", 8'h30);
    send(0, 3, 0, 8'h31);
    send(0, 3, 0, 8'h32);
    send(0, 3, 1, 8'h33);
    ack();
    next_disp("R4 miss first", 8'h33);
    ack();
    next_disp("R5 oldest done", 8'h31);
    ack();
    next_disp("R5 younger done", 8'h32);
    ack();
  endtask

  task automatic t_os();
    send(1, 5, 0, 8'h40);
    check("R7 unregistered os", os_valid, 1);
    check("R7 unregistered tag", os_tag, 8'h40);
    tbl(1, 1, 5, 32'hB000_0200, 32'h0000_BEEF);
    send(1, 5, 0, 8'h41);
    check("R6 not running os", os_valid, 1);
    check("R6 os_thread", os_thread, 1);
    check("R6 os_tag", os_tag, 8'h41);
    send(0, 4, 1, 8'h42);
    check("R7 source mismatch os", os_valid, 1);
    check("R7 os_src", os_src, 4);
    check("R7 os_tag", os_tag, 8'h42);
    quiet_disp("R6 R7 none dispatched", 4);
  endtask

  task automatic t_full();
    send(0, 3, 0, 8'h50);
    next_disp("R8 head", 8'h50);
    for (int k = 1; k <= 4; k++) begin
      send(0, 3, 0, 8'(8'h50 + k));
      check("R8 queued not os", os_valid, 0);
    end
    send(0, 3, 0, 8'h55);
    check("R8 full to os", os_valid, 1);
    check("R8 full tag", os_tag, 8'h55);
    for (int k = 1; k <= 4; k++) begin
      ack();
      next_disp("R8 kept", 8'(8'h50 + k));
    end
    ack();
  endtask

  task automatic t_clear();
    logic [TGW-1:0] got [2];
    int n = 0;
    send(0, 3, 0, 8'h60);
    next_disp("R9 head", 8'h60);
    send(0, 3, 0, 8'h61);
    send(0, 3, 1, 8'h62);
    tbl(0, 0, 0, '0, '0);
    for (int c = 0; c < 6; c++) begin
      if (os_valid && n < 2) begin got[n] = os_tag; n++; end
      tick();
    end
    check("R9 drained count", n, 2);
    check("R9 oldest first", got[0], 8'h61);
    check("R9 second", got[1], 8'h62);
    ack();
    quiet_disp("R9 no dispatch after clear", 4);
    tbl(0, 1, 3, 32'hA000_0100, 32'h0000_CAFE);
  endtask

  task automatic t_switch();
    int n = 0;
    logic [TGW-1:0] got = '0;
    send(0, 3, 0, 8'h70);
    next_disp("R10 head", 8'h70);
    send(0, 3, 1, 8'h71);
    @(negedge clk);
    cur_thread = 1;
    for (int c = 0; c < 5; c++) begin
      tick();
      if (os_valid) begin got = os_tag; n++; end
    end
    check("R10 drained once", n, 1);
    check("R10 drained tag", got, 8'h71);
    ack();
    quiet_disp("R10 no dispatch", 3);
    @(negedge clk);
    cur_thread = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_handshake();
    t_prio();
    t_os();
    t_full();
    t_clear();
    t_switch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule